// File: doc/BRIEF.md
# Vector High-Half Move Unit

This unit executes a packed single-precision "move high 64 bits" operation for a SIMD register file whose widest register holds `VL` bits (128, 256 or 512; default 512). A decoder upstream supplies the opcode byte, the encoding class, the addressing-mode field, the second-operand register selector, the vector-length code and the width bit. It also supplies the values of the destination register, of the operand register and the 64-bit word read from memory. The unit returns one of three results: a full-width register write-back, a 64-bit store word, or an invalid-opcode fault.

A load inserts the memory word into bits 127:64 of the destination. The legacy class leaves every other bit as it was. The two extended classes take bits 63:0 from the operand register and clear everything above bit 127. A store sends bits 127:64 of the operand register to memory. Every result is registered once, so the result for an operation appears on the clock edge after it is presented.

Top module: `hq_move_unit`

## Requirements
- R1: Opcode byte 0x16 selects the load and 0x17 selects the store. Any other opcode byte, and encoding class code 3, raise `fault`. The class codes are: 0 legacy, 1 short extended, 2 wide extended.
- R2: Legacy load: `reg_wdata[127:64]` equals `mem_rdata`. All other bits of `reg_wdata` equal `dst_old`.
- R3: Extended load (class 1 or 2): `reg_wdata[63:0]` equals `opnd_val[63:0]`, `reg_wdata[127:64]` equals `mem_rdata`, and bits VL-1:128 are zero.
- R4: Any store: `mem_we` is 1, `mem_wdata` equals `opnd_val[127:64]`, and `reg_we` is 0. A load sets `reg_we` and leaves `mem_we` at 0.
- R5: An extended store whose `src_sel` is not 4'b1111 faults. The legacy class ignores `src_sel`.
- R6: Class 1 faults when `len_code[0]` is 1 and ignores `len_code[1]`. Class 2 faults on any nonzero `len_code`. The legacy class ignores `len_code`.
- R7: An `addr_mode` of 2'b11 (register operand) faults in every class.
- R8: Class 2 faults when `w_bit` is 1. Classes 0 and 1 ignore `w_bit`.
- R9: A faulting operation leaves `reg_we` and `mem_we` low, and drives `reg_wdata` and `mem_wdata` to zero.
- R10: `out_valid` equals `in_valid` delayed by one clock. A cycle with `in_valid` low produces no enable and no fault.
- R11: A synchronous active-low reset clears `out_valid`, `fault` and both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| enc_class | input | 2 | 0 legacy, 1 short extended, 2 wide extended |
| opcode | input | 8 | Opcode byte: 0x16 load, 0x17 store |
| addr_mode | input | 2 | Addressing-mode field; 3 means register operand |
| src_sel | input | 4 | Second-source selector field |
| len_code | input | 2 | Vector-length code |
| w_bit | input | 1 | Operand width bit |
| dst_old | input | VL | Current destination register value |
| opnd_val | input | VL | Operand register value (low-half source on load, data source on store) |
| mem_rdata | input | 64 | Memory word for a load |
| out_valid | output | 1 | A result is present |
| reg_we | output | 1 | Register write-back enable |
| reg_wdata | output | VL | Register write-back value |
| mem_we | output | 1 | Memory store enable |
| mem_wdata | output | 64 | Memory store value |
| fault | output | 1 | Invalid-opcode fault |

## Verification
Assertions check the following on every cycle: the one-clock valid latency, the two enables never being asserted together, silence on a fault, the store word, the legacy preservation of the low half and the upper-bit clearing for the extended classes. Only the bench scenarios can show some other behaviour. These are the exact decode of each fault condition, the fields that each class ignores (width bit, second length bit, selector), that an unknown opcode or class code faults, and that reset clears a result in flight.

// File: rtl/hq_move_unit.sv
module hq_move_unit #(
  parameter int VL = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    enc_class,
  input  logic [7:0]    opcode,
  input  logic [1:0]    addr_mode,
  input  logic [3:0]    src_sel,
  input  logic [1:0]    len_code,
  input  logic          w_bit,
  input  logic [VL-1:0] dst_old,
  input  logic [VL-1:0] opnd_val,
  input  logic [63:0]   mem_rdata,
  output logic          out_valid,
  output logic          reg_we,
  output logic [VL-1:0] reg_wdata,
  output logic          mem_we,
  output logic [63:0]   mem_wdata,
  output logic          fault
);
  localparam logic [7:0] OP_LOAD  = 8'h16;
  localparam logic [7:0] OP_STORE = 8'h17;

  logic is_ld, is_st, is_short, is_wide, ext, bad, do_ld, do_st;
  logic [VL-1:0] ld_val;

  assign is_ld    = opcode == OP_LOAD;
  assign is_st    = opcode == OP_STORE;
  assign is_short = enc_class == 2'd1;
  assign is_wide  = enc_class == 2'd2;
  assign ext      = is_short || is_wide;

  assign bad = (!is_ld && !is_st)
            || (enc_class == 2'd3)
            || (addr_mode == 2'b11)
            || (is_short && len_code[0])
            || (is_wide && len_code != 2'b00)
            || (is_wide && w_bit)
            || (ext && is_st && src_sel != 4'hF);

  assign do_ld = in_valid && !bad && is_ld;
  assign do_st = in_valid && !bad && is_st;

  always_comb begin
    ld_val          = ext ? '0 : dst_old;
    ld_val[63:0]    = ext ? opnd_val[63:0] : dst_old[63:0];
    ld_val[127:64]  = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      reg_we    <= 1'b0;
      mem_we    <= 1'b0;
      fault     <= 1'b0;
      reg_wdata <= '0;
      mem_wdata <= '0;
    end else begin
      out_valid <= in_valid;
      reg_we    <= do_ld;
      mem_we    <= do_st;
      fault     <= in_valid && bad;
      reg_wdata <= do_ld ? ld_val : '0;
      mem_wdata <= do_st ? opnd_val[127:64] : 64'd0;
    end
  end

  // R10
  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !reg_we && !mem_we && !fault);
  // R4
  p_one_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && mem_we));
  p_store_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !mem_we || mem_wdata == $past(opnd_val[127:64]));
  // R9
  p_fault_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !reg_we && !mem_we && reg_wdata == '0 && mem_wdata == 64'd0);
  // R7
  p_regform_faults_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && addr_mode == 2'b11 |=> fault);
  // R2
  p_legacy_low_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && enc_class == 2'd0 |=> !reg_we || reg_wdata[63:0] == $past(dst_old[63:0]));
  // R3
  p_ext_high_from_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !reg_we || reg_wdata[127:64] == $past(mem_rdata));

  generate
    if (VL > 128) begin : g_upper
      p_ext_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && enc_class != 2'd0 |=> !reg_we || reg_wdata[VL-1:128] == '0);
    end
  endgenerate
endmodule

// File: tb/tb_hq_move_unit.sv
module tb_hq_move_unit;
  localparam int VL = 512;

  typedef struct packed {
    logic [1:0] enc;
    logic [7:0] op;
    logic [1:0] mode;
    logic [3:0] sel;
    logic [1:0] len;
    logic       w;
    logic [1:0] kind; // 0 fault, 1 load, 2 store
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h16, 2'd0, 4'h0, 2'd0, 1'b0, 2'd1}, // R2 legacy load
    '{2'd0, 8'h16, 2'd2, 4'h5, 2'd3, 1'b1, 2'd1}, // R5 R6 R8 legacy ignores fields
    '{2'd1, 8'h16, 2'd1, 4'h3, 2'd0, 1'b1, 2'd1}, // R3 R8 short ignores w
    '{2'd2, 8'h16, 2'd0, 4'h7, 2'd0, 1'b0, 2'd1}, // R3 wide load
    '{2'd0, 8'h17, 2'd0, 4'h2, 2'd0, 1'b0, 2'd2}, // R4 R5 legacy store
    '{2'd1, 8'h17, 2'd0, 4'hF, 2'd0, 1'b0, 2'd2}, // R4 short store
    '{2'd2, 8'h17, 2'd1, 4'hF, 2'd0, 1'b0, 2'd2}, // R4 wide store
    '{2'd1, 8'h17, 2'd0, 4'hE, 2'd0, 1'b0, 2'd0}, // R5
    '{2'd2, 8'h17, 2'd0, 4'h0, 2'd0, 1'b0, 2'd0}, // R5
    '{2'd1, 8'h16, 2'd0, 4'h1, 2'd1, 1'b0, 2'd0}, // R6
    '{2'd1, 8'h16, 2'd0, 4'h1, 2'd2, 1'b0, 2'd1}, // R6 bit1 ignored
    '{2'd2, 8'h16, 2'd0, 4'h1, 2'd2, 1'b0, 2'd0}, // R6
    '{2'd2, 8'h16, 2'd0, 4'h1, 2'd0, 1'b1, 2'd0}, // R8
    '{2'd0, 8'h16, 2'd3, 4'h0, 2'd0, 1'b0, 2'd0}, // R7
    '{2'd1, 8'h17, 2'd3, 4'hF, 2'd0, 1'b0, 2'd0}, // R7
    '{2'd0, 8'h18, 2'd0, 4'h0, 2'd0, 1'b0, 2'd0}, // R1 unknown opcode
    '{2'd3, 8'h16, 2'd0, 4'h0, 2'd0, 1'b0, 2'd0}  // R1 unknown class
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, w_bit = 1'b0;
  logic [1:0] enc_class = '0, addr_mode = '0, len_code = '0;
  logic [7:0] opcode = '0;
  logic [3:0] src_sel = '0;
  logic [VL-1:0] dst_old, opnd_val, reg_wdata;
  logic [63:0] mem_rdata, mem_wdata;
  logic out_valid, reg_we, mem_we, fault;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  hq_move_unit #(.VL(VL)) dut (.*);

  task automatic chk(input bit ok, input string req, input string detail);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, detail);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1'b1; enc_class = v.enc; opcode = v.op; addr_mode = v.mode;
    src_sel = v.sel; len_code = v.len; w_bit = v.w;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    logic [VL-1:0] exp_reg;
    chk(out_valid == 1'b1, "R10", $sformatf("vec %0d out_valid act %b exp 1", idx, out_valid));
    chk(fault == (v.kind == 2'd0), "R1", $sformatf("vec %0d fault act %b exp %b", idx, fault, v.kind == 2'd0));
    chk(reg_we == (v.kind == 2'd1) && mem_we == (v.kind == 2'd2), "R4",
        $sformatf("vec %0d reg_we/mem_we act %b%b kind %0d", idx, reg_we, mem_we, v.kind));
    if (v.kind == 2'd1) begin
      if (v.enc == 2'd0) begin
        exp_reg = dst_old;
        exp_reg[127:64] = mem_rdata;
        chk(reg_wdata == exp_reg, "R2", $sformatf("vec %0d reg_wdata act %h exp %h", idx, reg_wdata, exp_reg));
      end else begin
        exp_reg = '0;
        exp_reg[63:0] = opnd_val[63:0];
        exp_reg[127:64] = mem_rdata;
        chk(reg_wdata == exp_reg, "R3", $sformatf("vec %0d reg_wdata act %h exp %h", idx, reg_wdata, exp_reg));
      end
    end else if (v.kind == 2'd2) begin
      chk(mem_wdata == opnd_val[127:64], "R4",
          $sformatf("vec %0d mem_wdata act %h exp %h", idx, mem_wdata, opnd_val[127:64]));
    end else begin
      chk(reg_wdata == '0 && mem_wdata == 64'd0, "R9",
          $sformatf("vec %0d data act %h/%h exp 0", idx, reg_wdata[127:0], mem_wdata));
    end
  endtask

  initial begin
    dst_old   = {4{64'hD1D1_2222_D1D1_3333, 64'hD0D0_4444_D0D0_5555}};
    dst_old[VL-1 -: 64] = 64'hFEED_0000_BEEF_0001;
    opnd_val  = {4{64'h0BAD_CAFE_0000_1111, 64'h2222_3333_4444_5555}};
    mem_rdata = 64'h1234_5678_9ABC_DEF0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!out_valid && !reg_we && !mem_we && !fault, "R11",
        $sformatf("reset act v%b r%b m%b f%b exp 0000", out_valid, reg_we, mem_we, fault));
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      mem_rdata = mem_rdata + 64'h0101_0101_0101_0101;
      @(negedge clk);
      check_vec(VECS[i], i);
    end
    // R10 idle cycle with a faulting pattern on the fields
    in_valid = 1'b0; opcode = 8'h00;
    @(negedge clk);
    chk(!out_valid && !reg_we && !mem_we && !fault, "R10",
        $sformatf("idle act v%b r%b m%b f%b exp 0000", out_valid, reg_we, mem_we, fault));
    // R10 back-to-back load then store
    drive(VECS[3]);
    @(negedge clk);
    check_vec(VECS[3], 3);
    drive(VECS[6]);
    @(negedge clk);
    check_vec(VECS[6], 6);
    // R11 reset clears a result in flight
    drive(VECS[0]);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && !reg_we && !fault, "R11",
        $sformatf("reset in flight act v%b r%b f%b exp 000", out_valid, reg_we, fault));
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R10", $sformatf("after reset act %b exp 0", out_valid));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog expired act hung exp done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule